// File: doc/BRIEF.md
# Sparse-Address UART Bank Chip-Select Decoder

This block connects one chip-select window of a host's asynchronous memory-style bus to a bank of sixteen byte-wide UART devices. The host decodes a 16 MB window. Inside that window the block takes four scattered byte-address bits as a device number and turns them into a one-hot device select. Three further address bits give a register number, because the device registers sit 64 bytes apart. Every other address bit is ignored, so each device's registers repeat many times across the window.

Writes go to the selected device only. The device always sees the low byte of the host data bus. On a read, the selected device's byte is returned on the low byte lane and the high lane is zero. This keeps reads and writes correct whether the host bus runs 8 bits wide or 16 bits wide. The sixteen device interrupt requests are merged into one shared active-high line. A per-device pending vector is also provided.

The block samples the host strobes and address in its own clock domain. Every output is registered, so it changes one clock after the inputs that cause it. The host's access timing must allow for that cycle.

Top module: `uart_bank_csdec`

## Requirements
- R1: While `cs_n` is low, `dev_sel` is one-hot one clock later. The set bit is the device number {addr[16], addr[15], addr[12], addr[9]}, where addr[16] is the MSB and addr[9] is the LSB. For example, offset 0x1200 selects device 3 and offset 0x10000 selects device 8.
- R2: While `cs_n` is high, `dev_sel`, `dev_wr` and `rd_oe` are all zero one clock later, whatever `oe_n` and `we_n` do.
- R3: `dev_reg` equals addr[8:6] one clock later, so register n sits at byte offset n*64 from its device base.
- R4: Address bits 5:0, 11:10, 14:13 and 23:17 have no effect on any output. Device registers therefore alias within the window.
- R5: When `cs_n` and `we_n` are both low, `dev_wr` has only the selected device's bit set one clock later. Otherwise `dev_wr` is zero. `dev_wdata` always carries `host_wdata[7:0]`, and `host_wdata[15:8]` is ignored.
- R6: When `cs_n` and `oe_n` are both low, `rd_oe` is 1 one clock later. In the same cycle `host_rdata` is {8'h00, byte of the selected device}. Device k's byte is `dev_rdata[8k+7:8k]`.
- R7: When `oe_n` or `cs_n` is high, `rd_oe` is 0 and `host_rdata` is zero one clock later.
- R8: `irq` is the OR of all sixteen `dev_irq` bits, and it is active high. `irq_pending` equals `dev_irq`. Both are registered with one clock of delay.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host chip-select for the UART window, active low |
| oe_n | input | 1 | Host output enable (read strobe), active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | 24 | Byte address within the 16 MB window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the host data pads |
| rd_oe | output | 1 | Pad drive enable for `host_rdata`; the pads float when it is 0 |
| dev_sel | output | 16 | One-hot device selects |
| dev_wr | output | 16 | Per-device write strobes |
| dev_reg | output | 3 | Register index for the devices |
| dev_wdata | output | 8 | Write byte for the devices |
| dev_rdata | input | 128 | Packed read bytes, device k at bits 8k+7:8k |
| dev_irq | input | 16 | Device interrupt requests, active high |
| irq | output | 1 | Shared interrupt, active high |
| irq_pending | output | 16 | Copy of the device requests |

## Verification
A directed walk over all sixteen device bases checks the scattered bit weighting. Each device is given a distinct read byte, so a swapped bit or a wrong lane in the read multiplexer shows up as a wrong value. Random addresses fill every bit that is not decoded with noise. A result that changes with that noise exposes a missing alias or the wrong register bits. Random mixes of chip-select, read and write strobes separate the select, write and read gating from each other, including cycles where the strobes are active while chip-select is high. Single-hot and all-zero interrupt patterns show that the merge is an OR and that the pending bits stay in their own positions.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int NUM_DEV  = 16;
    localparam int DEV_IW   = $clog2(NUM_DEV);
    localparam int REG_IW   = 3;
    localparam int REG_LSB  = 6;
    localparam int DEV_DW   = 8;
    localparam int BUS_DW   = 16;
    localparam int HADDR_W  = 24;
    // byte-address bit feeding each device-index bit, index 0 = LSB
    localparam int DEV_BIT_POS [DEV_IW] = '{9, 12, 15, 16};
endpackage

// File: rtl/csdec_addr_map.sv
module csdec_addr_map #(
    parameter int AW      = csdec_pkg::HADDR_W,
    parameter int IW      = csdec_pkg::DEV_IW,
    parameter int RW      = csdec_pkg::REG_IW,
    parameter int REG_LSB = csdec_pkg::REG_LSB
) (
    input  logic [AW-1:0] addr,
    output logic [IW-1:0] dev_idx,
    output logic [RW-1:0] reg_idx
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^addr;

    for (genvar i = 0; i < IW; i++) begin : g_pick
        assign dev_idx[i] = addr[csdec_pkg::DEV_BIT_POS[i]];
    end

    assign reg_idx = addr[REG_LSB +: RW];
endmodule

// File: rtl/csdec_onehot.sv
module csdec_onehot #(
    parameter int N  = csdec_pkg::NUM_DEV,
    parameter int IW = csdec_pkg::DEV_IW
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  vec
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign vec[i] = en && (idx == IW'(i));
    end
endmodule

// File: rtl/csdec_rd_mux.sv
module csdec_rd_mux #(
    parameter int N  = csdec_pkg::NUM_DEV,
    parameter int IW = csdec_pkg::DEV_IW,
    parameter int DW = csdec_pkg::DEV_DW
) (
    input  logic [N*DW-1:0] lanes,
    input  logic [IW-1:0]   idx,
    output logic [DW-1:0]   byte_out
);
    logic [DW-1:0] lane_arr [N];

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign lane_arr[i] = lanes[i*DW +: DW];
    end

    assign byte_out = lane_arr[idx];
endmodule

// File: rtl/uart_bank_csdec.sv
module uart_bank_csdec #(
    parameter int N_DEV   = csdec_pkg::NUM_DEV,
    parameter int AW      = csdec_pkg::HADDR_W,
    parameter int RW      = csdec_pkg::REG_IW,
    parameter int REG_LSB = csdec_pkg::REG_LSB,
    parameter int DDW     = csdec_pkg::DEV_DW,
    parameter int BDW     = csdec_pkg::BUS_DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic [AW-1:0]        addr,
    input  logic [BDW-1:0]       host_wdata,
    output logic [BDW-1:0]       host_rdata,
    output logic                 rd_oe,
    output logic [N_DEV-1:0]     dev_sel,
    output logic [N_DEV-1:0]     dev_wr,
    output logic [RW-1:0]        dev_reg,
    output logic [DDW-1:0]       dev_wdata,
    input  logic [N_DEV*DDW-1:0] dev_rdata,
    input  logic [N_DEV-1:0]     dev_irq,
    output logic                 irq,
    output logic [N_DEV-1:0]     irq_pending
);
    localparam int IW = $clog2(N_DEV);

    typedef struct packed {
        logic [N_DEV-1:0] sel;
        logic [N_DEV-1:0] wr;
        logic [RW-1:0]    reg_idx;
        logic [DDW-1:0]   wdata;
        logic [BDW-1:0]   rdata;
        logic             rdata_oe;
        logic             irq;
        logic [N_DEV-1:0] pending;
    } stage_t;

    stage_t stage_d, stage_q;

    logic             cs_act;
    logic             rd_act;
    logic             wr_act;
    logic [IW-1:0]    dev_idx;
    logic [RW-1:0]    reg_idx;
    logic [N_DEV-1:0] sel_vec;
    logic [DDW-1:0]   rd_byte;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^host_wdata[BDW-1:DDW];

    assign cs_act = !cs_n;
    assign rd_act = cs_act && !oe_n;
    assign wr_act = cs_act && !we_n;

    csdec_addr_map #(
        .AW(AW), .IW(IW), .RW(RW), .REG_LSB(REG_LSB)
    ) u_map (
        .addr    (addr),
        .dev_idx (dev_idx),
        .reg_idx (reg_idx)
    );

    csdec_onehot #(
        .N(N_DEV), .IW(IW)
    ) u_sel (
        .en  (cs_act),
        .idx (dev_idx),
        .vec (sel_vec)
    );

    csdec_rd_mux #(
        .N(N_DEV), .IW(IW), .DW(DDW)
    ) u_rmux (
        .lanes    (dev_rdata),
        .idx      (dev_idx),
        .byte_out (rd_byte)
    );

    always_comb begin
        stage_d          = '0;
        stage_d.sel      = sel_vec;
        stage_d.wr       = wr_act ? sel_vec : '0;
        stage_d.reg_idx  = reg_idx;
        stage_d.wdata    = host_wdata[DDW-1:0];
        stage_d.rdata    = rd_act ? {{(BDW-DDW){1'b0}}, rd_byte} : '0;
        stage_d.rdata_oe = rd_act;
        stage_d.irq      = |dev_irq;
        stage_d.pending  = dev_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dev_sel     = stage_q.sel;
    assign dev_wr      = stage_q.wr;
    assign dev_reg     = stage_q.reg_idx;
    assign dev_wdata   = stage_q.wdata;
    assign host_rdata  = stage_q.rdata;
    assign rd_oe       = stage_q.rdata_oe;
    assign irq         = stage_q.irq;
    assign irq_pending = stage_q.pending;
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker #(
    parameter int N_DEV = 16,
    parameter int BDW   = 16,
    parameter int DDW   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             oe_n,
    input logic             we_n,
    input logic [N_DEV-1:0] dev_sel,
    input logic [N_DEV-1:0] dev_wr,
    input logic [BDW-1:0]   host_rdata,
    input logic             rd_oe,
    input logic [N_DEV-1:0] dev_irq,
    input logic             irq,
    input logic [N_DEV-1:0] irq_pending
);
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cs_n)) |-> $onehot(dev_sel));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cs_n)) |-> (dev_sel == '0 && dev_wr == '0 && !rd_oe));

    a_r5_wr_in_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr & ~dev_sel) == '0);

    a_r5_wr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_n)) |-> dev_wr == '0);

    a_r6_hi_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> host_rdata[BDW-1:DDW] == '0);

    a_r7_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(oe_n) || $past(cs_n))) |-> (!rd_oe && host_rdata == '0));

    a_r8_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == (|$past(dev_irq)) && irq_pending == $past(dev_irq)));
endmodule

bind uart_bank_csdec csdec_checker #(
    .N_DEV(N_DEV), .BDW(BDW), .DDW(DDW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .dev_sel     (dev_sel),
    .dev_wr      (dev_wr),
    .host_rdata  (host_rdata),
    .rd_oe       (rd_oe),
    .dev_irq     (dev_irq),
    .irq         (irq),
    .irq_pending (irq_pending)
);

// File: tb/uart_bank_csdec_tb.sv
module uart_bank_csdec_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cs_n, oe_n, we_n;
    logic [23:0]  addr;
    logic [15:0]  host_wdata;
    logic [15:0]  host_rdata;
    logic         rd_oe;
    logic [15:0]  dev_sel, dev_wr;
    logic [2:0]   dev_reg;
    logic [7:0]   dev_wdata;
    logic [127:0] dev_rdata;
    logic [15:0]  dev_irq;
    logic         irq;
    logic [15:0]  irq_pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_bank_csdec u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rd_oe(rd_oe), .dev_sel(dev_sel), .dev_wr(dev_wr), .dev_reg(dev_reg),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_irq(dev_irq),
        .irq(irq), .irq_pending(irq_pending)
    );

    function automatic logic [3:0] exp_idx(logic [23:0] a);
        return {a[16], a[15], a[12], a[9]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // drive at negedge, check just after the next posedge
    task automatic step(logic c, logic o, logic w, logic [23:0] a,
                        logic [15:0] wd, logic [127:0] rd, logic [15:0] iq);
        logic [15:0] e_sel, e_wr, e_rd;
        logic [3:0]  k;
        @(negedge clk);
        cs_n = c; oe_n = o; we_n = w; addr = a;
        host_wdata = wd; dev_rdata = rd; dev_irq = iq;
        k     = exp_idx(a);
        e_sel = c ? 16'h0 : (16'h1 << k);
        e_wr  = (c || w) ? 16'h0 : (16'h1 << k);
        e_rd  = (c || o) ? 16'h0 : {8'h00, rd[k*8 +: 8]};
        @(posedge clk);
        #1;
        chk("R1/R2 dev_sel", 32'(dev_sel), 32'(e_sel));
        chk("R5 dev_wr", 32'(dev_wr), 32'(e_wr));
        chk("R3 dev_reg", 32'(dev_reg), 32'(a[8:6]));
        chk("R5 dev_wdata", 32'(dev_wdata), 32'(wd[7:0]));
        chk("R6/R7 host_rdata", 32'(host_rdata), 32'(e_rd));
        chk("R6/R7 rd_oe", 32'(rd_oe), 32'(!c && !o));
        chk("R8 irq", 32'(irq), 32'(|iq));
        chk("R8 irq_pending", 32'(irq_pending), 32'(iq));
    endtask

    function automatic logic [127:0] tagged_bytes();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'hA0 + 8'(i * 3);
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [23:0] base [4];
        logic [23:0] a;
        void'($urandom(32'd1234));
        rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        addr = '0; host_wdata = '0; dev_rdata = '1; dev_irq = '1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state with active-looking inputs
        chk("R9 sel", 32'(dev_sel), 0);
        chk("R9 rdata", 32'(host_rdata), 0);
        chk("R9 irq", 32'(irq), 0);
        chk("R9 pending", 32'(irq_pending), 0);
        chk("R9 oe", 32'(rd_oe), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R6: walk every device base, reading distinct bytes
        base = '{24'h0, 24'h200, 24'h1000, 24'h8000};
        for (int d = 0; d < 16; d++) begin
            a = 24'(d[0]) << 9 | 24'(d[1]) << 12 | 24'(d[2]) << 15 | 24'(d[3]) << 16;
            step(1'b0, 1'b0, 1'b1, a, 16'h0, tagged_bytes(), 16'h1 << d);
        end
        // R1: offset 0x1200 -> device 3, 0x10000 -> device 8
        step(1'b0, 1'b1, 1'b1, 24'h001200, 16'h0, tagged_bytes(), 16'h0);
        chk("R1 dev3", 32'(dev_sel), 32'h0008);
        step(1'b0, 1'b1, 1'b1, 24'h010000, 16'h0, tagged_bytes(), 16'h0);
        chk("R1 dev8", 32'(dev_sel), 32'h0100);
        // R3: each register offset n*64
        for (int r = 0; r < 8; r++)
            step(1'b0, 1'b1, 1'b0, 24'h009200 | 24'(r << 6), 16'hFF00 | 16'(r), tagged_bytes(), 16'h0);
        // R4: aliasing through ignored bits gives identical results
        for (int j = 0; j < 4; j++)
            step(1'b0, 1'b0, 1'b1, base[j] | 24'hFE6C3F, 16'h0, tagged_bytes(), 16'h8000);
        // R2/R7: strobes active with chip-select high
        step(1'b1, 1'b0, 1'b0, 24'h019240, 16'h55AA, tagged_bytes(), 16'h0);
        chk("R2 sel idle", 32'(dev_sel), 0);
        chk("R7 no drive", 32'(rd_oe), 0);

        // random mix
        for (int t = 0; t < 3000; t++) begin
            logic [127:0] rv;
            for (int q = 0; q < 4; q++) rv[q*32 +: 32] = $urandom;
            step(($urandom % 5) == 0, $urandom % 2, $urandom % 2, 24'($urandom),
                 16'($urandom), rv, ($urandom % 3 == 0) ? 16'h0 : 16'($urandom));
        end

        done = 1;
        summary();
    end
endmodule